// File: doc/BRIEF.md
# Periodic Coprocessor Wakeup Sequencer

This block runs a low-power coprocessor on a repeating schedule set by a slow-clock tick strobe. Software programs a period (in ticks), a power-good delay (in ticks) and an entry address through a small write port, then issues a run command. The run command copies those three values into working copies and arms the period timer. When the period has elapsed, the block powers the coprocessor, waits for the power-good delay, and pulses start with the entry address presented. It then waits for the coprocessor to finish.

A run ends when the coprocessor reports done or raises a trap. The block then removes power and re-arms the timer with the same working period. A trap also pulses a host wake line. A sticky status field records why the last run ended, and the host can clear it. Clearing the enable bit, from the host or from the coprocessor, ends the loop. The run in progress still completes, but no further power-up follows.

Top module: `wk_seq`

## Requirements
- R1: After reset, cp_pwr_o, cp_start_o and host_wake_o are 0 and halt_cause_o is 0. Ticks produce no power-up until a run command is written, even when the enable bit alone is set.
- R2: Write port map: address 0 holds the period, 1 is control, 2 holds the entry address, 3 holds the power-good delay. Control bits are bit 0 enable, bit 1 run, bit 2 clear-status. A control write with bit 1 set, issued while the block is idle, captures period, delay and entry and arms the timer. cp_pwr_o rises in the cycle after the tick that completes the period.
- R3: A period of 0 behaves as a period of 1 tick.
- R4: With a delay of M ticks, cp_start_o is 0 while powered and rises in the cycle after the M-th tick counted while powered. With M = 0, it rises one cycle after cp_pwr_o. cp_start_o is a one-cycle pulse, occurs only while cp_pwr_o is 1, and is accompanied by cp_entry_o equal to the captured entry.
- R5: Done during a run drops cp_pwr_o in the next cycle and re-arms the timer with the captured period. Period writes made without a new run command do not change it.
- R6: A trap during a run drops cp_pwr_o and pulses host_wake_o for exactly one cycle, in the next cycle. Done alone never pulses host_wake_o.
- R7: halt_cause_o holds 1 after a done and 2 after a trap, and 2 when both arrive in the same cycle. It keeps its value until a control write with bit 2 set returns it to 0.
- R8: A control write with bits 0 and 1 clear, or a pulse on cp_timer_off_i, clears enable. The current run still completes, and no further power-up happens on later ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | DATA_W | Write data |
| tick_i | input | 1 | Slow-clock tick strobe, one cycle per tick |
| cp_done_i | input | 1 | Coprocessor reports its program finished |
| cp_trap_i | input | 1 | Coprocessor trapped on illegal state |
| cp_timer_off_i | input | 1 | Coprocessor request to clear enable |
| cp_pwr_o | output | 1 | Coprocessor power request |
| cp_start_o | output | 1 | One-cycle start pulse |
| cp_entry_o | output | ADDR_W | Captured entry address |
| host_wake_o | output | 1 | Host wake pulse on trap |
| halt_cause_o | output | 2 | Sticky last halt cause: 0 none, 1 done, 2 trap |

## Verification
The bench builds the block with a 6-bit period counter and a 3-bit power-good counter. This makes the all-ones limits, 63 ticks and 7 ticks, cheap to reach in a directed pass, alongside random small periods and delays that include zero. The narrow counters also make the terminal count on every limit value frequent. That shows a counter that wraps or stops one short, and a zero that is not promoted to one.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_PWRUP,
    ST_START,
    ST_RUN
  } wk_state_e;

  typedef enum logic [1:0] {
    HALT_NONE = 2'd0,
    HALT_DONE = 2'd1,
    HALT_TRAP = 2'd2
  } halt_e;

  localparam logic [1:0] A_PERIOD = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_ENTRY  = 2'd2;
  localparam logic [1:0] A_PGOOD  = 2'd3;

  localparam int C_EN  = 0;
  localparam int C_RUN = 1;
  localparam int C_CLR = 2;
endpackage

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PG_W   = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cp_off_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [PG_W-1:0]   pgood_o,
  output logic [ADDR_W-1:0] entry_o,
  output logic              en_o,
  output logic              run_o,
  output logic              clr_o
);
  logic ctrl_wr;
  logic unused_bits;

  assign ctrl_wr     = wr_en_i && (wr_addr_i == A_CTRL);
  assign run_o       = ctrl_wr && wr_data_i[C_RUN];
  assign clr_o       = ctrl_wr && wr_data_i[C_CLR];
  assign unused_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      pgood_o  <= '0;
      entry_o  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_PERIOD) period_o <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == A_PGOOD)  pgood_o  <= wr_data_i[PG_W-1:0];
      if (wr_addr_i == A_ENTRY)  entry_o  <= wr_data_i[ADDR_W-1:0];
    end
  end

  // host write wins over a same-cycle coprocessor clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= 1'b0;
    else if (ctrl_wr)  en_o <= wr_data_i[C_EN] | wr_data_i[C_RUN];
    else if (cp_off_i) en_o <= 1'b0;
  end

  p_off_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_off_i && !ctrl_wr) |=> !en_o);
  p_run_sets_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> en_o);
endmodule

// File: rtl/wk_tick_cnt.sv
module wk_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;

  // zero limit counts as one tick
  assign lim_eff = (limit_i == '0) ? W'(1) : limit_i;
  assign hit_o   = active_i && tick_i && (cnt_q >= lim_eff - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!active_i)   cnt_q <= '0;
    else if (hit_o)       cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + W'(1);
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_eff);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/wk_fsm.sv
module wk_fsm
  import wk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       en_i,
  input  logic       per_hit_i,
  input  logic       pg_hit_i,
  input  logic       pg_zero_i,
  input  logic       done_i,
  input  logic       trap_i,
  input  logic       clr_i,
  output logic       latch_o,
  output logic       per_act_o,
  output logic       pg_act_o,
  output logic       pwr_o,
  output logic       start_o,
  output logic       wake_o,
  output logic [1:0] cause_o
);
  wk_state_e st_q, st_d;
  halt_e     cause_q;
  logic      halt;

  assign halt      = (st_q == ST_RUN) && (done_i || trap_i);
  assign latch_o   = (st_q == ST_IDLE) && run_i;
  assign per_act_o = (st_q == ST_ARMED);
  assign pg_act_o  = (st_q == ST_PWRUP);
  assign pwr_o     = (st_q == ST_PWRUP) || (st_q == ST_START) || (st_q == ST_RUN);
  assign start_o   = (st_q == ST_START);
  assign cause_o   = cause_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (run_i) st_d = ST_ARMED;
      ST_ARMED: begin
        if (!en_i)          st_d = ST_IDLE;
        else if (per_hit_i) st_d = ST_PWRUP;
      end
      ST_PWRUP: if (pg_zero_i || pg_hit_i) st_d = ST_START;
      ST_START: st_d = ST_RUN;
      ST_RUN:   if (halt) st_d = en_i ? ST_ARMED : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cause_q <= HALT_NONE;
      wake_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_o <= halt && trap_i;
      if (halt)       cause_q <= trap_i ? HALT_TRAP : HALT_DONE;
      else if (clr_i) cause_q <= HALT_NONE;
    end
  end

  p_halt_pwrdn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !pwr_o);
  p_wake_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cause_q == HALT_TRAP));
  p_trap_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && trap_i) |=> (cause_q == HALT_TRAP));
  p_start_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_no_rerun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !en_i) |=> !pwr_o);
endmodule

// File: rtl/wk_seq.sv
module wk_seq
  import wk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PG_W   = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic              cp_done_i,
  input  logic              cp_trap_i,
  input  logic              cp_timer_off_i,
  output logic              cp_pwr_o,
  output logic              cp_start_o,
  output logic [ADDR_W-1:0] cp_entry_o,
  output logic              host_wake_o,
  output logic [1:0]        halt_cause_o
);
  logic [CNT_W-1:0]  reg_period, act_period;
  logic [PG_W-1:0]   reg_pgood, act_pgood;
  logic [ADDR_W-1:0] reg_entry, act_entry;
  logic en, run, clr, latch;
  logic per_act, pg_act, per_hit, pg_hit;

  wk_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PG_W(PG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cp_off_i (cp_timer_off_i),
    .period_o (reg_period),
    .pgood_o  (reg_pgood),
    .entry_o  (reg_entry),
    .en_o     (en),
    .run_o    (run),
    .clr_o    (clr)
  );

  // working copies, taken only when a run is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_period <= '0;
      act_pgood  <= '0;
      act_entry  <= '0;
    end else if (latch) begin
      act_period <= reg_period;
      act_pgood  <= reg_pgood;
      act_entry  <= reg_entry;
    end
  end

  wk_tick_cnt #(.W(CNT_W)) u_per_cnt (
    .clk_i, .rst_ni,
    .active_i (per_act),
    .tick_i,
    .limit_i  (act_period),
    .hit_o    (per_hit)
  );

  wk_tick_cnt #(.W(PG_W)) u_pg_cnt (
    .clk_i, .rst_ni,
    .active_i (pg_act),
    .tick_i,
    .limit_i  (act_pgood),
    .hit_o    (pg_hit)
  );

  wk_fsm u_fsm (
    .clk_i, .rst_ni,
    .run_i     (run),
    .en_i      (en),
    .per_hit_i (per_hit),
    .pg_hit_i  (pg_hit),
    .pg_zero_i (act_pgood == '0),
    .done_i    (cp_done_i),
    .trap_i    (cp_trap_i),
    .clr_i     (clr),
    .latch_o   (latch),
    .per_act_o (per_act),
    .pg_act_o  (pg_act),
    .pwr_o     (cp_pwr_o),
    .start_o   (cp_start_o),
    .wake_o    (host_wake_o),
    .cause_o   (halt_cause_o)
  );

  assign cp_entry_o = act_entry;

  p_start_pwr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_start_o |-> cp_pwr_o);
  p_pwr_before_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_pwr_o) |-> !cp_start_o);
  p_wake_only_trap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_wake_o) |-> $past(cp_trap_i));
endmodule

// File: tb/wk_seq_bench.sv
module wk_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int PG_W   = 3;
  localparam int ADDR_W = 32;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              wr_en_i = 1'b0;
  logic [1:0]        wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              tick_i = 1'b0;
  logic              cp_done_i = 1'b0;
  logic              cp_trap_i = 1'b0;
  logic              cp_timer_off_i = 1'b0;
  logic              cp_pwr_o, cp_start_o, host_wake_o;
  logic [ADDR_W-1:0] cp_entry_o;
  logic [1:0]        halt_cause_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  wk_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PG_W(PG_W), .ADDR_W(ADDR_W)) u_wk_seq (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .tick_i,
    .cp_done_i, .cp_trap_i, .cp_timer_off_i,
    .cp_pwr_o, .cp_start_o, .cp_entry_o, .host_wake_o, .halt_cause_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [1:0] exp_cause(input int kind);
    return (kind == 0) ? 2'd1 : 2'd2;  // done=1, trap or both=2
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic tick1();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  // timer to power-up to start; ends in the run state
  task automatic run_cycle(input int p, input int m, input logic [31:0] e);
    for (int i = 1; i <= eff(p); i++) begin
      tick1();
      chk((p == 0) ? "R3 zero period" : "R2 power-up tick", 32'(cp_pwr_o), 32'(i == eff(p)));
      if (i < eff(p) && ($urandom % 3 == 0)) begin
        step();
        chk("R2 idle gap", 32'(cp_pwr_o), 32'd0);
      end
    end
    chk("R4 no start at power-up", 32'(cp_start_o), 32'd0);
    if (m == 0) begin
      step();
      chk("R4 start with zero delay", 32'(cp_start_o), 32'd1);
    end else begin
      for (int j = 1; j <= m; j++) begin
        tick1();
        chk("R4 power-good delay", 32'(cp_start_o), 32'(j == m));
        chk("R4 power held", 32'(cp_pwr_o), 32'd1);
      end
    end
    chk("R4 entry", cp_entry_o, e);
    step();
    chk("R4 start single", 32'(cp_start_o), 32'd0);
    chk("R4 powered in run", 32'(cp_pwr_o), 32'd1);
  endtask

  task automatic halt(input int kind);
    cp_done_i = (kind != 1);
    cp_trap_i = (kind != 0);
    step();
    cp_done_i = 1'b0; cp_trap_i = 1'b0;
    chk("R5 power down", 32'(cp_pwr_o), 32'd0);
    chk("R6 wake on trap", 32'(host_wake_o), 32'(kind != 0));
    chk("R7 halt cause", 32'(halt_cause_o), 32'(exp_cause(kind)));
    step();
    chk("R6 wake pulse ends", 32'(host_wake_o), 32'd0);
    chk("R7 cause sticky", 32'(halt_cause_o), 32'(exp_cause(kind)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state and no counting without run
    chk("R1 reset pwr", 32'(cp_pwr_o), 32'd0);
    chk("R1 reset start", 32'(cp_start_o), 32'd0);
    chk("R1 reset wake", 32'(host_wake_o), 32'd0);
    chk("R1 reset cause", 32'(halt_cause_o), 32'd0);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h1);  // enable only, no run
    for (int k = 0; k < 5; k++) begin
      tick1();
      chk("R1 no run no power", 32'(cp_pwr_o), 32'd0);
    end
    wr(2'd1, 32'h0);

    for (int it = 0; it < 24; it++) begin
      int p, m, p2, kind;
      logic [31:0] e;
      p = $urandom % 10;
      m = $urandom % 4;
      e = $urandom;
      kind = $urandom % 3;
      if (it == 0) begin p = 0; m = 0; end
      if (it == 1) begin p = 63; m = 7; kind = 2; end
      if (it == 2) begin p = 1; m = 1; end
      p2 = (p + 1 + ($urandom % 5)) % 64;

      wr(2'd0, 32'(p));
      wr(2'd3, 32'(m));
      wr(2'd2, e);
      wr(2'd1, 32'h3);
      run_cycle(p, m, e);

      wr(2'd0, 32'(p2));  // R5 no effect until next run
      halt(kind);

      run_cycle(p, m, e);  // R5 re-armed with captured period
      if ($urandom % 2 == 0) wr(2'd1, 32'h0);  // R8 host clear
      else begin
        cp_timer_off_i = 1'b1; step(); cp_timer_off_i = 1'b0;  // R8 coprocessor clear
      end
      chk("R8 run continues", 32'(cp_pwr_o), 32'd1);
      halt(0);
      for (int k = 0; k < eff(p) + 3; k++) begin
        tick1();
        chk("R8 loop stopped", 32'(cp_pwr_o), 32'd0);
      end
      wr(2'd1, 32'h4);
      chk("R7 host clear", 32'(halt_cause_o), 32'd0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule